// File: doc/BRIEF.md
# Pointer-Based Hard-Fault Repair Unit

This block hides permanently stuck cells in wide memory lines. For each line it keeps a short list of repair entries. An entry records the position of one failed bit and the value that bit ought to hold. On a read, the raw line fetched from the array passes through the block. Every valid entry of that line forces its bit to the stored value. On a write, the block captures, for each valid entry of the target line, the bit of the write data at the entry's position. A later read then returns the intended data, even though the array cell cannot hold it.

A separate fault port reports a newly found hard fault as a line, a bit position and a correct value. The block gives the fault the lowest unused entry of that line. Entries are applied in index order, so a later entry that names the same position overrides an earlier one. This lets a spare entry repair a fault that sits inside an earlier entry's stored value. When every entry of a line is in use, the line is flagged full. A fault reported against a full line is refused and signalled as uncorrectable. Detecting faults, correcting soft errors and remapping lines are left to other blocks.

Top module: `ecp_repair_unit`

## Requirements
- R1: After reset every entry is invalid, `line_full` is all zeros, `uncorr` is 0, and `rd_fixed` equals `rd_raw` for every line.
- R2: `rd_fixed` is `rd_raw` with, for each valid entry of line `rd_line`, bit number `ptr` replaced by the entry's stored value. All other bits pass unchanged, combinationally.
- R3: A fault (`flt_en`=1) on a line that is not full is placed in the lowest-numbered invalid entry of `flt_line`, with pointer `flt_pos` and value `flt_val`. The entry takes effect on reads from the cycle after the clock edge that samples it.
- R4: When two valid entries of a line name the same position, the entry with the higher index decides the read value of that bit.
- R5: A write (`wr_en`=1) sets the stored value of every valid entry of `wr_line` to `wr_data[ptr]`, effective after the sampling edge. Entries of other lines keep their values.
- R6: When a write and an accepted fault target the same line in one cycle, the new entry takes `flt_val`, and the older entries take the write data.
- R7: `line_full[l]` rises in the cycle after the edge that fills the last entry of line `l`. It stays set until reset.
- R8: A fault reported against a full line changes no entry and drives `uncorr` to 1 for exactly the cycle after its sampling edge.
- R9: `uncorr` stays 0 after any cycle with no fault, and after a fault on a line that is not full.
- R10: The entries of one line never alter the read data of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_line | input | LIDX_W (2) | Line whose entries apply to the read path |
| rd_raw | input | LINE_W (512) | Raw line data from the array |
| rd_fixed | output | LINE_W (512) | Repaired read data |
| wr_en | input | 1 | Write of `wr_data` to line `wr_line` is taking place |
| wr_line | input | LIDX_W (2) | Line being written |
| wr_data | input | LINE_W (512) | Intended write data |
| flt_en | input | 1 | A new hard fault is reported |
| flt_line | input | LIDX_W (2) | Line holding the fault |
| flt_pos | input | PTR_W (9) | Bit position of the failed cell |
| flt_val | input | 1 | Correct value for the failed position |
| line_full | output | NUM_LINES (4) | Per line: all entries are used |
| uncorr | output | 1 | One-cycle pulse: a fault was refused because its line was full |

## Verification
The hardest state to reach is a line carrying two entries that point at the same position, followed by a write. Both entries then hold copies of the write bit, and the higher one must still win on later reads. The stimulus allocates an entry at a position that is already repaired, using the opposite value, and then writes data that flips that bit. Once the line has filled, it reports one more fault and confirms that the read data does not change. Boundary positions 0 and 511, and a write and a fault on the same line in one cycle, are driven on purpose. After that, a long random phase is compared against a behavioural model on every clock.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
   localparam int unsigned DEF_LINE_W  = 512;
   localparam int unsigned DEF_ENTRIES = 6;
   localparam int unsigned DEF_LINES   = 4;

   // Decision taken for a reported fault in one cycle.
   typedef enum logic [1:0] {
      FLT_IDLE   = 2'd0,
      FLT_TAKE   = 2'd1,
      FLT_REJECT = 2'd2
   } flt_act_e;

   function automatic bit is_pow2(int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/ecp_free_pick.sv
module ecp_free_pick #(
   parameter int unsigned ENTRIES = 6,
   parameter int unsigned EIDX_W  = 3
) (
   input  logic [ENTRIES-1:0] used,
   output logic [EIDX_W-1:0]  idx,
   output logic               any_free
);
   if (ENTRIES == 1) begin : g_single
      assign idx      = '0;
      assign any_free = ~used[0];
   end else begin : g_multi
      always_comb begin
         idx      = '0;
         any_free = 1'b0;
         for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (!used[k]) begin
               idx      = EIDX_W'(k);
               any_free = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ecp_overlay.sv
module ecp_overlay #(
   parameter int unsigned LINE_W  = 512,
   parameter int unsigned ENTRIES = 6,
   parameter int unsigned PTR_W   = 9
) (
   input  logic [LINE_W-1:0]        raw,
   input  logic [ENTRIES-1:0]       ent_vld,
   input  logic [ENTRIES*PTR_W-1:0] ent_ptr,
   input  logic [ENTRIES-1:0]       ent_val,
   output logic [LINE_W-1:0]        fixed
);
   // One stage per entry; higher index sits later and wins on a shared position.
   for (genvar k = 0; k < ENTRIES; k++) begin : g_stage
      logic [LINE_W-1:0] prev;
      logic [LINE_W-1:0] hit;
      logic [LINE_W-1:0] out;
      if (k == 0) begin : g_first
         assign prev = raw;
      end else begin : g_next
         assign prev = g_stage[k-1].out;
      end
      assign hit = ent_vld[k] ? (LINE_W'(1) << ent_ptr[k*PTR_W +: PTR_W]) : '0;
      assign out = (prev & ~hit) | (ent_val[k] ? hit : '0);
   end

   assign fixed = g_stage[ENTRIES-1].out;
endmodule

// File: rtl/ecp_entry_table.sv
module ecp_entry_table
   import ecp_pkg::*;
#(
   parameter int unsigned LINE_W  = 512,
   parameter int unsigned ENTRIES = 6,
   parameter int unsigned LINES   = 4,
   parameter int unsigned PTR_W   = 9,
   parameter int unsigned LIDX_W  = 2,
   parameter int unsigned EIDX_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [LIDX_W-1:0]        wr_line,
   input  logic [LINE_W-1:0]        wr_data,
   input  logic                     flt_en,
   input  logic [LIDX_W-1:0]        flt_line,
   input  logic [PTR_W-1:0]         flt_pos,
   input  logic                     flt_val,
   input  logic [LIDX_W-1:0]        rd_line,
   output logic [ENTRIES-1:0]       rd_vld,
   output logic [ENTRIES*PTR_W-1:0] rd_ptr,
   output logic [ENTRIES-1:0]       rd_val,
   output logic [LINES-1:0]         line_full,
   output logic                     uncorr
);
   logic [ENTRIES-1:0]       vld_q [LINES];
   logic [ENTRIES*PTR_W-1:0] ptr_q [LINES];
   logic [ENTRIES-1:0]       val_q [LINES];
   logic                     uncorr_q;

   logic [EIDX_W-1:0] pick;
   logic              any_free;
   flt_act_e          act;

   ecp_free_pick #(
      .ENTRIES (ENTRIES),
      .EIDX_W  (EIDX_W)
   ) pick_i (
      .used     (vld_q[flt_line]),
      .idx      (pick),
      .any_free (any_free)
   );

   always_comb begin
      if (!flt_en)       act = FLT_IDLE;
      else if (any_free) act = FLT_TAKE;
      else               act = FLT_REJECT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            vld_q[l] <= '0;
            ptr_q[l] <= '0;
            val_q[l] <= '0;
         end
         uncorr_q <= 1'b0;
      end else begin
         uncorr_q <= (act == FLT_REJECT);
         if (wr_en) begin
            for (int k = 0; k < ENTRIES; k++) begin
               if (vld_q[wr_line][k])
                  val_q[wr_line][k] <= wr_data[ptr_q[wr_line][k*PTR_W +: PTR_W]];
            end
         end
         // Placed after the write update so a fresh entry keeps the reported value.
         if (act == FLT_TAKE) begin
            vld_q[flt_line][pick]                 <= 1'b1;
            ptr_q[flt_line][pick*PTR_W +: PTR_W]  <= flt_pos;
            val_q[flt_line][pick]                 <= flt_val;
         end
      end
   end

   for (genvar l = 0; l < LINES; l++) begin : g_full
      assign line_full[l] = &vld_q[l];
   end

   assign rd_vld = vld_q[rd_line];
   assign rd_ptr = ptr_q[rd_line];
   assign rd_val = val_q[rd_line];
   assign uncorr = uncorr_q;
endmodule

// File: rtl/ecp_repair_unit.sv
module ecp_repair_unit
   import ecp_pkg::*;
#(
   parameter int unsigned LINE_W    = DEF_LINE_W,
   parameter int unsigned ENTRIES   = DEF_ENTRIES,
   parameter int unsigned NUM_LINES = DEF_LINES,
   localparam int unsigned PTR_W    = $clog2(LINE_W),
   localparam int unsigned LIDX_W   = $clog2(NUM_LINES),
   localparam int unsigned EIDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LIDX_W-1:0]    rd_line,
   input  logic [LINE_W-1:0]    rd_raw,
   output logic [LINE_W-1:0]    rd_fixed,
   input  logic                 wr_en,
   input  logic [LIDX_W-1:0]    wr_line,
   input  logic [LINE_W-1:0]    wr_data,
   input  logic                 flt_en,
   input  logic [LIDX_W-1:0]    flt_line,
   input  logic [PTR_W-1:0]     flt_pos,
   input  logic                 flt_val,
   output logic [NUM_LINES-1:0] line_full,
   output logic                 uncorr
);
   if (!is_pow2(LINE_W) || LINE_W < 2) begin : g_bad_width
      $error("ecp_repair_unit: LINE_W must be a power of two of at least 2");
   end
   if (!is_pow2(NUM_LINES) || NUM_LINES < 2) begin : g_bad_lines
      $error("ecp_repair_unit: NUM_LINES must be a power of two of at least 2");
   end
   if (ENTRIES < 1 || ENTRIES > 64) begin : g_bad_entries
      $error("ecp_repair_unit: ENTRIES must lie in 1..64");
   end

   logic [ENTRIES-1:0]       ent_vld;
   logic [ENTRIES*PTR_W-1:0] ent_ptr;
   logic [ENTRIES-1:0]       ent_val;

   ecp_entry_table #(
      .LINE_W  (LINE_W),
      .ENTRIES (ENTRIES),
      .LINES   (NUM_LINES),
      .PTR_W   (PTR_W),
      .LIDX_W  (LIDX_W),
      .EIDX_W  (EIDX_W)
   ) table_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_line   (wr_line),
      .wr_data   (wr_data),
      .flt_en    (flt_en),
      .flt_line  (flt_line),
      .flt_pos   (flt_pos),
      .flt_val   (flt_val),
      .rd_line   (rd_line),
      .rd_vld    (ent_vld),
      .rd_ptr    (ent_ptr),
      .rd_val    (ent_val),
      .line_full (line_full),
      .uncorr    (uncorr)
   );

   ecp_overlay #(
      .LINE_W  (LINE_W),
      .ENTRIES (ENTRIES),
      .PTR_W   (PTR_W)
   ) overlay_i (
      .raw     (rd_raw),
      .ent_vld (ent_vld),
      .ent_ptr (ent_ptr),
      .ent_val (ent_val),
      .fixed   (rd_fixed)
   );
endmodule

// File: rtl/ecp_repair_checker.sv
module ecp_repair_checker #(
   parameter int unsigned LINE_W    = 512,
   parameter int unsigned ENTRIES   = 6,
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned LIDX_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 flt_en,
   input logic [LIDX_W-1:0]    flt_line,
   input logic [LINE_W-1:0]    rd_raw,
   input logic [LINE_W-1:0]    rd_fixed,
   input logic [NUM_LINES-1:0] line_full,
   input logic                 uncorr
);
   assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (line_full == '0 && !uncorr));

   assert_bounded_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_fixed ^ rd_raw) <= ENTRIES);

   assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(line_full) & ~line_full) == '0));

   assert_full_needs_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_full & ~$past(line_full)) != '0) |-> $past(flt_en));

   assert_refuse_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr |-> $past(line_full[flt_line]));

   assert_quiet_without_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flt_en) |-> !uncorr);
endmodule

bind ecp_repair_unit ecp_repair_checker #(
   .LINE_W    (LINE_W),
   .ENTRIES   (ENTRIES),
   .NUM_LINES (NUM_LINES),
   .LIDX_W    (LIDX_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .flt_en    (flt_en),
   .flt_line  (flt_line),
   .rd_raw    (rd_raw),
   .rd_fixed  (rd_fixed),
   .line_full (line_full),
   .uncorr    (uncorr)
);

// File: tb/ecp_repair_unit_tb_top.sv
`timescale 1ns/1ps
module ecp_repair_unit_tb_top;
   localparam int LW = 512;
   localparam int NE = 6;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    rd_line;
   logic [LW-1:0] rd_raw;
   logic [LW-1:0] rd_fixed;
   logic          wr_en;
   logic [1:0]    wr_line;
   logic [LW-1:0] wr_data;
   logic          flt_en;
   logic [1:0]    flt_line;
   logic [8:0]    flt_pos;
   logic          flt_val;
   logic [NL-1:0] line_full;
   logic          uncorr;

   int n_tests = 0;
   int n_fail  = 0;

   // Behavioural reference state
   bit m_vld [NL][NE];
   int m_ptr [NL][NE];
   bit m_val [NL][NE];
   bit m_unc;

   always #10 clk = ~clk;

   ecp_repair_unit dut_i (
      .clk(clk), .rst_n(rst_n), .rd_line(rd_line), .rd_raw(rd_raw),
      .rd_fixed(rd_fixed), .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
      .flt_en(flt_en), .flt_line(flt_line), .flt_pos(flt_pos), .flt_val(flt_val),
      .line_full(line_full), .uncorr(uncorr)
   );

   function automatic logic [LW-1:0] rand_line();
      logic [LW-1:0] v;
      for (int w = 0; w < LW / 32; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic bit m_full(int l);
      for (int k = 0; k < NE; k++) if (!m_vld[l][k]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check_now(string tag);
      logic [LW-1:0] exp_fix;
      logic [NL-1:0] exp_full;
      #1;
      exp_fix = rd_raw;
      for (int k = 0; k < NE; k++)
         if (m_vld[rd_line][k]) exp_fix[m_ptr[rd_line][k]] = m_val[rd_line][k];
      for (int l = 0; l < NL; l++) exp_full[l] = m_full(l);
      n_tests++;
      if (rd_fixed !== exp_fix) begin
         n_fail++;
         $display("FAIL %s rd_fixed act=%h exp=%h", tag, rd_fixed, exp_fix);
      end
      n_tests++;
      if (line_full !== exp_full) begin
         n_fail++;
         $display("FAIL %s line_full act=%b exp=%b", tag, line_full, exp_full);
      end
      n_tests++;
      if (uncorr !== m_unc) begin
         n_fail++;
         $display("FAIL %s uncorr act=%b exp=%b", tag, uncorr, m_unc);
      end
   endtask

   // Check, let one edge pass, advance the model, return at the next falling edge.
   task automatic cyc(string tag);
      bit full_now;
      check_now(tag);
      @(posedge clk);
      full_now = m_full(flt_line);
      m_unc = flt_en && full_now;
      if (wr_en)
         for (int k = 0; k < NE; k++)
            if (m_vld[wr_line][k]) m_val[wr_line][k] = wr_data[m_ptr[wr_line][k]];
      if (flt_en && !full_now) begin
         for (int k = 0; k < NE; k++) begin
            if (!m_vld[flt_line][k]) begin
               m_vld[flt_line][k] = 1'b1;
               m_ptr[flt_line][k] = flt_pos;
               m_val[flt_line][k] = flt_val;
               break;
            end
         end
      end
      @(negedge clk);
      wr_en  = 1'b0;
      flt_en = 1'b0;
   endtask

   task automatic fault(int l, int p, bit v, string tag);
      flt_en = 1'b1; flt_line = 2'(l); flt_pos = 9'(p); flt_val = v;
      cyc(tag);
   endtask

   task automatic read(int l, string tag);
      rd_line = 2'(l); rd_raw = rand_line();
      cyc(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rd_line = '0; rd_raw = '0; wr_en = 1'b0; wr_line = '0;
      wr_data = '0; flt_en = 1'b0; flt_line = '0; flt_pos = '0; flt_val = 1'b0;
      m_unc = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int l = 0; l < NL; l++) read(l, "R1");

      // Allocation order and boundary positions
      fault(0, 5, 1'b1, "R3");
      rd_line = 0; rd_raw = '0; cyc("R3");
      fault(0, 511, 1'b0, "R3");
      fault(0, 0, 1'b1, "R3");
      rd_line = 0; rd_raw = '1; cyc("R2");
      rd_line = 0; rd_raw = '0; cyc("R2");
      read(0, "R2");

      // Later entry on the same position wins
      fault(0, 5, 1'b0, "R4");
      rd_line = 0; rd_raw = '1; cyc("R4");
      read(1, "R10");

      // Write captures intended bits; other lines untouched
      fault(2, 300, 1'b1, "R3");
      wr_en = 1'b1; wr_line = 0; wr_data = rand_line(); wr_data[5] = 1'b1;
      cyc("R5");
      read(0, "R5");
      read(2, "R5");
      rd_line = 0; rd_raw = '0; cyc("R4");

      // Write and fault on one line in one cycle
      fault(1, 7, 1'b0, "R3");
      wr_en = 1'b1; wr_line = 1; wr_data = rand_line();
      flt_en = 1'b1; flt_line = 1; flt_pos = 9; flt_val = ~wr_data[9];
      cyc("R6");
      read(1, "R6");

      // Fill line 0, then refuse
      fault(0, 200, 1'b1, "R7");
      fault(0, 201, 1'b0, "R7");
      read(0, "R7");
      fault(0, 202, 1'b1, "R8");
      rd_line = 0; rd_raw = '0; cyc("R8");
      fault(2, 12, 1'b0, "R9");
      read(2, "R9");
      read(3, "R10");

      // Random phase
      for (int i = 0; i < 400; i++) begin
         rd_line = 2'($urandom); rd_raw = rand_line();
         wr_en = 1'($urandom % 3 == 0); wr_line = 2'($urandom); wr_data = rand_line();
         flt_en = 1'($urandom % 4 == 0); flt_line = 2'($urandom);
         flt_pos = 9'($urandom % 16); flt_val = 1'($urandom);
         cyc("R2");
      end
      check_now("R7");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule